// File: doc/BRIEF.md
# Sixteen-Operation Arithmetic Logic Unit with Status Flags

This block is the combinational arithmetic logic unit of a small processor. Two operand words, `a` and `b`, come straight from fixed registers. A 4-bit operation code from the control unit picks one of sixteen functions:

- arithmetic: add, subtract, increment, decrement, negate;
- bitwise logic: and, or, xor, invert;
- single-position shifts and rotates of `a`;
- data movement: pass `a`, pass `b`, clear.

The result goes toward the data bus. Four status bits describe the result: zero, carry, sign and signed overflow.

The result port carries the computed word only while the output-enable input is high. With the enable low, the port reads all zeros. The status bits always describe the computed word, whatever the enable does, so the control unit can test a condition without driving the bus.

The word width is a parameter, `W`, with a default of 8 and a minimum of 2. The flag rules scale with it: "most negative" means only the top bit set, and "largest positive" means every bit set except the top one.

Top module: `alu16_top`

## Requirements
- R1: Code 0000 yields `a`, code 0001 yields `b`, and code 1111 yields an all-zero word.
- R2: Code 0010 yields `a + b` modulo 2^W. Carry is the bit out of the top position. Overflow is set when both operands have the same sign and the result sign differs from it.
- R3: Code 0011 yields `a - b`, formed as `a + ~b + 1`. Carry is the bit out of that sum, so 1 means no borrow (`a >= b` unsigned). Overflow is set when `a` and `b` differ in sign and the result sign differs from `a`'s.
- R4: Codes 0100, 0101, 0110 and 0111 yield `a & b`, `a | b`, `a ^ b` and `~a`.
- R5: Code 1100 yields `a + 1` and code 1101 yields `a - 1`. For increment, carry is set only when `a` is all ones, and overflow only when `a` is the largest positive value. For decrement, carry (no borrow) is set only when `a` is not zero, and overflow only when `a` is the most negative value.
- R6: Code 1110 yields the two's complement `-a`. Carry is set only when `a` is zero, and overflow only when `a` is the most negative value.
- R7: Code 1000 shifts `a` left by one position and fills a 0 at the bottom; carry takes the old top bit. Code 1001 shifts `a` right by one position and fills a 0 at the top; carry takes the old bottom bit.
- R8: Code 1010 rotates `a` left by one position; the old top bit moves to the bottom and is copied to carry. Code 1011 rotates `a` right by one position; the old bottom bit moves to the top and is copied to carry.
- R9: `zf` is 1 exactly when the computed word is all zeros, whether or not `oe` is high.
- R10: `sf` always equals the top bit of the computed word.
- R11: Carry and overflow are both 0 for codes 0000, 0001, 0100 to 0111 and 1111. Overflow is 0 for codes 1000 to 1011.
- R12: While `oe` is low, `result` is all zeros and the four flags keep the values they have with `oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand; also the sole operand of the single-operand functions |
| b | input | W | Second operand |
| op | input | 4 | Operation code |
| oe | input | 1 | Result drive enable |
| result | output | W | Computed word while `oe` is high, zero otherwise |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry / no-borrow flag |
| sf | output | 1 | Sign flag |
| vf | output | 1 | Signed overflow flag |

## Verification
The bench builds two instances: one at the default width of 8 and one at width 4. The 8-bit unit gets random operands under every code, plus a directed cross of the values zero, one, largest positive, most negative and all ones. The 4-bit unit is small enough to walk every operand pair under every code. That exhausts every carry, borrow and overflow boundary of the adder and every bit that shifts or rotates out.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_PASS_A = 4'h0,
    OP_PASS_B = 4'h1,
    OP_ADD    = 4'h2,
    OP_SUB    = 4'h3,
    OP_AND    = 4'h4,
    OP_OR     = 4'h5,
    OP_XOR    = 4'h6,
    OP_NOT    = 4'h7,
    OP_SHL    = 4'h8,
    OP_SHR    = 4'h9,
    OP_ROL    = 4'hA,
    OP_ROR    = 4'hB,
    OP_INC    = 4'hC,
    OP_DEC    = 4'hD,
    OP_NEG    = 4'hE,
    OP_ZERO   = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_MOVE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2,
    GRP_SHIFT = 2'd3
  } alu_grp_e;

  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic v;
  } alu_flags_t;

  // Classify an operation so the result and flag muxes pick one source.
  function automatic alu_grp_e op_group(input alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: return GRP_ARITH;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR:         return GRP_SHIFT;
      OP_AND, OP_OR, OP_XOR, OP_NOT:          return GRP_LOGIC;
      default:                                return GRP_MOVE;
    endcase
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] NONE     = '0;

  // Adder operands, selected per operation, brought out as named wires.
  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_cin;

  // One shared adder: returns {carry, sum}.
  function automatic logic [W:0] add_with_carry(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input logic         ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  // Signed overflow of x + y: operands agree in sign, sum disagrees.
  function automatic logic signed_ovf(input logic xs, input logic ys,
                                      input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  always_comb begin
    add_x   = a;
    add_y   = NONE;
    add_cin = 1'b0;
    case (op)
      OP_ADD: begin add_y = b;        add_cin = 1'b0; end
      OP_SUB: begin add_y = ~b;       add_cin = 1'b1; end
      OP_INC: begin add_y = NONE;     add_cin = 1'b1; end
      OP_DEC: begin add_y = ALL_ONES; add_cin = 1'b0; end
      OP_NEG: begin add_x = NONE; add_y = ~a; add_cin = 1'b1; end
      default: ;
    endcase
  end

  logic [W:0] add_full;
  assign add_full = add_with_carry(add_x, add_y, add_cin);
  assign sum      = add_full[W-1:0];
  assign cout     = add_full[W];
  assign ovf      = signed_ovf(add_x[W-1], add_y[W-1], add_full[W-1]);

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_PASS_A: res = a;
      OP_PASS_B: res = b;
      OP_AND:    res = a & b;
      OP_OR:     res = a | b;
      OP_XOR:    res = a ^ b;
      OP_NOT:    res = ~a;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         cout
);

  localparam int MSB = W - 1;

  // Bit that leaves the word, and the bit that enters at the vacated end.
  logic out_bit;
  logic fill_bit;
  logic go_left;

  assign go_left  = (op == OP_SHL) || (op == OP_ROL);
  assign out_bit  = go_left ? a[MSB] : a[0];
  assign fill_bit = ((op == OP_ROL) || (op == OP_ROR)) ? out_bit : 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_low
        assign res[i] = go_left ? fill_bit : a[i+1];
      end else if (i == MSB) begin : g_high
        assign res[i] = go_left ? a[i-1] : fill_bit;
      end else begin : g_mid
        assign res[i] = go_left ? a[i-1] : a[i+1];
      end
    end
  endgenerate

  assign cout = out_bit;

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  alu_grp_e     grp,
  input  logic         arith_c,
  input  logic         arith_v,
  input  logic         shift_c,
  output alu_flags_t   flags
);

  always_comb begin
    flags.z = ~|res;
    flags.s = res[W-1];
    case (grp)
      GRP_ARITH: begin flags.c = arith_c; flags.v = arith_v; end
      GRP_SHIFT: begin flags.c = shift_c; flags.v = 1'b0;    end
      default:   begin flags.c = 1'b0;    flags.v = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         oe,
  output logic [W-1:0] result,
  output logic         zf,
  output logic         cf,
  output logic         sf,
  output logic         vf
);

  alu_op_e      op_e;
  alu_grp_e     grp;
  logic [W-1:0] arith_res;
  logic         arith_c;
  logic         arith_v;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic         shift_c;
  logic [W-1:0] core_res;
  alu_flags_t   flags;

  assign op_e = alu_op_e'(op);
  assign grp  = op_group(op_e);

  alu16_arith #(.W(W)) u_arith (
    .a(a), .b(b), .op(op_e), .sum(arith_res), .cout(arith_c), .ovf(arith_v)
  );

  alu16_logic #(.W(W)) u_logic (
    .a(a), .b(b), .op(op_e), .res(logic_res)
  );

  alu16_shift #(.W(W)) u_shift (
    .a(a), .op(op_e), .res(shift_res), .cout(shift_c)
  );

  always_comb begin
    case (grp)
      GRP_ARITH: core_res = arith_res;
      GRP_SHIFT: core_res = shift_res;
      default:   core_res = logic_res;
    endcase
  end

  alu16_flags #(.W(W)) u_flags (
    .res(core_res), .grp(grp), .arith_c(arith_c), .arith_v(arith_v),
    .shift_c(shift_c), .flags(flags)
  );

  assign result = oe ? core_res : '0;
  assign zf     = flags.z;
  assign cf     = flags.c;
  assign sf     = flags.s;
  assign vf     = flags.v;

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic         oe,
  input logic [W-1:0] result,
  input logic         zf,
  input logic         cf,
  input logic         sf,
  input logic         vf
);

  logic [W:0] wide_sum;
  logic       is_plain;
  assign wide_sum = {1'b0, a} + {1'b0, b};
  assign is_plain = (op == 4'h0) || (op == 4'h1) || (op == 4'hF) ||
                    (op[3:2] == 2'b01);

  always_comb begin
    p_bus_quiet_r12: assert (oe || (result == '0))
      else $error("result driven while oe low");
    p_zero_flag_r9: assert (!oe || ((result == '0) == zf))
      else $error("zero flag disagrees with result");
    p_sign_flag_r10: assert (!oe || (sf == result[W-1]))
      else $error("sign flag disagrees with result");
    p_no_carry_r11: assert (!is_plain || (!cf && !vf))
      else $error("carry or overflow on logic or move");
    p_shift_no_ovf_r11: assert ((op[3:2] != 2'b10) || !vf)
      else $error("overflow on shift or rotate");
    p_add_sum_r2: assert ((op != 4'h2) || !oe || ({cf, result} == wide_sum))
      else $error("add result or carry wrong");
    p_shl_carry_r7: assert ((op != 4'h8) || (cf == a[W-1]))
      else $error("shift-left carry wrong");
    p_rol_wrap_r8: assert ((op != 4'hA) || !oe || (result[0] == a[W-1]))
      else $error("rotate-left wrap bit wrong");
    p_neg_zero_r6: assert ((op != 4'hE) || (a != '0) || (cf && zf && !vf))
      else $error("negate of zero flags wrong");
  end

endmodule

bind alu16_top alu16_checker #(.W(W)) u_alu16_checker (
  .a(a), .b(b), .op(op), .oe(oe), .result(result),
  .zf(zf), .cf(cf), .sf(sf), .vf(vf)
);

// File: tb/alu16_top_bench.sv
module alu16_top_bench;

  localparam int WW = 8;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [WW-1:0] a_w, b_w, res_w;
  logic [3:0]    op_w;
  logic          oe_w, zf_w, cf_w, sf_w, vf_w;
  logic [WN-1:0] a_n, b_n, res_n;
  logic [3:0]    op_n;
  logic          oe_n, zf_n, cf_n, sf_n, vf_n;

  alu16_top #(.W(WW)) u_alu16_top (
    .a(a_w), .b(b_w), .op(op_w), .oe(oe_w), .result(res_w),
    .zf(zf_w), .cf(cf_w), .sf(sf_w), .vf(vf_w)
  );

  alu16_top #(.W(WN)) u_alu16_top_narrow (
    .a(a_n), .b(b_n), .op(op_n), .oe(oe_n), .result(res_n),
    .zf(zf_n), .cf(cf_n), .sf(sf_n), .vf(vf_n)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) cycles <= cycles + 1;

  function automatic string req_of(int op);
    case (op)
      0, 1, 15: return "R1";
      2:        return "R2";
      3:        return "R3";
      4, 5, 6, 7: return "R4";
      8, 9:     return "R7";
      10, 11:   return "R8";
      12, 13:   return "R5";
      default:  return "R6";
    endcase
  endfunction

  function automatic string cv_req(int op);
    if (op == 0 || op == 1 || op == 15 || (op >= 4 && op <= 7)) return "R11";
    return req_of(op);
  endfunction

  // Reference model over plain integers, width given at call time.
  function automatic void model(input int w, input int op, input int a,
                                input int b, output int res,
                                output bit c, output bit v);
    int mask = (1 << w) - 1;
    int top  = 1 << (w - 1);
    int s;
    c = 1'b0; v = 1'b0; res = 0;
    case (op)
      0: res = a;
      1: res = b;
      2: begin s = a + b; res = s & mask; c = ((s >> w) & 1) != 0;
               v = (((a ^ s) & (b ^ s) & top) != 0); end
      3: begin s = a + ((~b) & mask) + 1; res = s & mask;
               c = (a >= b); v = (((a ^ b) & (a ^ res) & top) != 0); end
      4: res = a & b;
      5: res = a | b;
      6: res = a ^ b;
      7: res = (~a) & mask;
      8: begin res = (a << 1) & mask; c = (a & top) != 0; end
      9: begin res = a >> 1; c = (a & 1) != 0; end
      10: begin res = ((a << 1) | (a >> (w - 1))) & mask; c = (a & top) != 0; end
      11: begin res = (a >> 1) | ((a & 1) << (w - 1)); c = (a & 1) != 0; end
      12: begin res = (a + 1) & mask; c = (a == mask); v = (a == top - 1); end
      13: begin res = (a - 1) & mask; c = (a != 0); v = (a == top); end
      14: begin res = (-a) & mask; c = (a == 0); v = (a == top); end
      default: res = 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act,
                     input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input bit narrow, input int op, input int a,
                       input int b, input bit oe);
    int w = narrow ? WN : WW;
    int top = 1 << (w - 1);
    int er, ar;
    bit ec, ev, az, ac, as_, av;
    @(posedge clk);
    if (narrow) begin
      a_n = a[WN-1:0]; b_n = b[WN-1:0]; op_n = op[3:0]; oe_n = oe;
    end else begin
      a_w = a[WW-1:0]; b_w = b[WW-1:0]; op_w = op[3:0]; oe_w = oe;
    end
    @(negedge clk);
    model(w, op, a, b, er, ec, ev);
    if (narrow) begin
      ar = int'(res_n); az = zf_n; ac = cf_n; as_ = sf_n; av = vf_n;
    end else begin
      ar = int'(res_w); az = zf_w; ac = cf_w; as_ = sf_w; av = vf_w;
    end
    if (oe) chk(req_of(op), "result", ar, er);
    else    chk("R12", "result with oe low", ar, 0);
    chk(cv_req(op), "carry", int'(ac), int'(ec));
    chk((op >= 8 && op <= 11) ? "R11" : cv_req(op), "overflow",
        int'(av), int'(ev));
    chk("R9", "zero flag", int'(az), int'(er == 0));
    chk("R10", "sign flag", int'(as_), int'((er & top) != 0));
  endtask

  initial begin
    int corners[5];
    int seed;
    a_w = '0; b_w = '0; op_w = 4'h0; oe_w = 1'b0;
    a_n = '0; b_n = '0; op_n = 4'h0; oe_n = 1'b0;
    seed = $urandom(32'h5EED_0A1C);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "initial result with oe low", int'(res_w), 0);
    chk("R9", "initial zero flag", int'(zf_w), 1);
    rst = 1'b0;

    // Directed corners at full width: zero, one, max positive, min negative, all ones.
    corners = '{0, 1, 8'h7F, 8'h80, 8'hFF};
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(1'b0, op, corners[i], corners[j], 1'b1);

    // R12: same operands with the enable low keep the flags.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        apply(1'b0, op, corners[i], corners[4 - i], 1'b0);

    // Random operands, random enable.
    for (int k = 0; k < 3000; k++)
      apply(1'b0, int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(255, 0)), ($urandom_range(3, 0) != 0));

    // Narrow width: every operand pair under every code.
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(1'b1, op, a, b, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule